// File: doc/BRIEF.md
# Flash Region Access Protection Unit

This block sits on the request path between a CPU bus and a flash array. It enforces write, erase and data-read permissions in 16 KB regions. Every request carries a kind: instruction fetch, data read, program (write) or sector erase. The block either forwards the request to the array unchanged, or blocks it. A blocked data read returns zero to the CPU instead of the array contents. Instruction fetches are never blocked, so code that is hidden from data reads can still run.

Two 8-bit protection words hold the permissions. A 0 in a bit protects the matching region and a 1 leaves it open. The words are loaded through a simple load port, which models the fetch from flash at reset. They can also be changed by programming their two flash word locations, 0x27FFC for write protection and 0x27FFE for read protection. Programming can only clear bits. Erasing the flash sector that holds the words sets both words back to all ones. A debug override input lifts all protection while it is held. A cleared reserved read bit raises a boot-failure flag.

Top module: `flash_guard`

## Requirements
- R1: After reset both protection words are 0xFF. Every request is then forwarded, `bootFail` is 0 and `violation` is 0.
- R2: Let the region index be i = (reqAddr >> 14) − 2. When write-protect bit i is 0 (i from 0 to 6, addresses 0x8000–0x23FFF), a write (kind 2) or erase (kind 3) in that region is not forwarded, and `flReqValid` is 0.
- R3: When read-protect bit i is 0 (i from 1 to 7, addresses 0xC000–0x27FFF), a data read (kind 1) in that region is not forwarded and `cpuRData` is 0x0000.
- R4: An instruction fetch (kind 0) is always forwarded and `cpuRData` equals `flRData`, whatever the read-protect word holds.
- R5: A request whose address is outside 0x8000–0x27FFF is always forwarded. The reserved bits (write bit 7, read bit 0) never protect anything.
- R6: An erase whose address is in the 4 KB sector holding 0x27FFC is always forwarded. From the next cycle on, both protection words are 0xFF.
- R7: While `dbgOverride` is 1, every request is forwarded and no data read is zeroed.
- R8: A forwarded write to 0x27FFC ANDs data bits [7:0] into the write-protect word, and bit 7 stays 1. A forwarded write to 0x27FFE ANDs data bits [7:0] into the read-protect word. Both take effect from the next cycle.
- R9: `bootFail` is 1 exactly while bit 0 of the read-protect word is 0.
- R10: `violation` is 1 in the cycle after a blocked write, a blocked erase or a zeroed data read, and 0 in the cycle after any other cycle.
- R11: A `loadValid` pulse loads `loadWp` (with bit 7 forced to 1) and `loadRp` into the protection words from the next cycle on. It takes priority over a same-cycle program or erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | CPU request present |
| reqKind | input | 2 | 0 fetch, 1 data read, 2 write, 3 sector erase |
| reqAddr | input | 18 | Byte address |
| reqWData | input | 16 | Write data |
| cpuRData | output | 16 | Read data returned to the CPU |
| dbgOverride | input | 1 | Disables all protection while high |
| loadValid | input | 1 | Load strobe for the protection words |
| loadWp | input | 8 | Write-protect word to load |
| loadRp | input | 8 | Read-protect word to load |
| flReqValid | output | 1 | Request forwarded to the array |
| flKind | output | 2 | Forwarded request kind |
| flAddr | output | 18 | Forwarded address |
| flWData | output | 16 | Forwarded write data |
| flRData | input | 16 | Read data from the array |
| violation | output | 1 | One-cycle flag for a blocked or zeroed access |
| bootFail | output | 1 | Reserved read bit cleared |

## Verification
Forwarding and the read-data substitution are combinational. The bench checks them shortly after it drives a request at the falling edge, in the same cycle. The violation flag and any change to a protection word appear only after the next rising edge. The bench reads the flag one time unit after that edge. It tests a new word value only with requests issued in later cycles. An idle cycle after a violation confirms that the pulse lasts a single cycle.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_ERASE = 2'd3
  } req_kind_e;

  typedef struct packed {
    logic fwd;
    logic zeroData;
    logic flagViol;
    logic progWp;
    logic progRp;
    logic restore;
    logic loadWords;
  } guard_strobe_t;
endpackage

// File: rtl/fg_ctrl.sv
module fg_ctrl
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int REGION_BITS = 14,
  parameter int BASE_REGION = 2,
  parameter int NUM_REGIONS = 8,
  parameter int SECTOR_BITS = 12,
  parameter int WP_ADDR     = 'h27FFC,
  parameter int RP_ADDR     = 'h27FFE
) (
  input  logic                   reqValid,
  input  logic [1:0]             reqKind,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic                   dbgOverride,
  input  logic                   loadValid,
  input  logic [NUM_REGIONS-1:0] wpWord,
  input  logic [NUM_REGIONS-1:0] rpWord,
  output guard_strobe_t          strobe
);
  localparam int IDX_W  = ADDR_W - REGION_BITS;
  localparam int LOC_W  = $clog2(NUM_REGIONS);
  localparam logic [ADDR_W-1:0] WP_A = ADDR_W'(WP_ADDR);
  localparam logic [ADDR_W-1:0] RP_A = ADDR_W'(RP_ADDR);
  localparam logic [IDX_W-1:0] IDX_LO = IDX_W'(BASE_REGION);
  localparam logic [IDX_W-1:0] IDX_HI = IDX_W'(BASE_REGION + NUM_REGIONS - 1);

  logic [IDX_W-1:0]       regionIdx;
  logic [LOC_W-1:0]       locIdx;
  logic                   inWindow;
  logic [NUM_REGIONS-1:0] wrOpen;
  logic [NUM_REGIONS-1:0] rdOpen;
  logic                   wrOk, rdOk, protSector;
  req_kind_e              kind;

  assign regionIdx = reqAddr[ADDR_W-1:REGION_BITS];
  assign inWindow  = (regionIdx >= IDX_LO) && (regionIdx <= IDX_HI);
  assign locIdx    = LOC_W'(regionIdx - IDX_LO);
  assign kind      = req_kind_e'(reqKind);

  // Reserved bits: top write bit and bottom read bit never protect.
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    if (g == NUM_REGIONS - 1) begin : g_wrRsv
      assign wrOpen[g] = 1'b1;
    end else begin : g_wrBit
      assign wrOpen[g] = wpWord[g];
    end
    if (g == 0) begin : g_rdRsv
      assign rdOpen[g] = 1'b1;
    end else begin : g_rdBit
      assign rdOpen[g] = rpWord[g];
    end
  end

  assign wrOk = dbgOverride || !inWindow || wrOpen[locIdx];
  assign rdOk = dbgOverride || !inWindow || rdOpen[locIdx];
  assign protSector = (reqAddr[ADDR_W-1:SECTOR_BITS] == WP_A[ADDR_W-1:SECTOR_BITS]);

  always_comb begin
    strobe = '0;
    strobe.loadWords = loadValid;
    if (reqValid) begin
      unique case (kind)
        KIND_FETCH: strobe.fwd = 1'b1;
        KIND_READ: begin
          strobe.fwd      = rdOk;
          strobe.zeroData = !rdOk;
          strobe.flagViol = !rdOk;
        end
        KIND_WRITE: begin
          strobe.fwd      = wrOk;
          strobe.flagViol = !wrOk;
          strobe.progWp   = wrOk && (reqAddr == WP_A);
          strobe.progRp   = wrOk && (reqAddr == RP_A);
        end
        KIND_ERASE: begin
          strobe.fwd      = wrOk || protSector;
          strobe.flagViol = !(wrOk || protSector);
          strobe.restore  = protSector;
        end
        default: strobe = '0;
      endcase
    end
  end

  // At most one kind of word update per request (R8, R6)
  always_comb begin
    a_single_update_r8: assert ($countones({strobe.progWp, strobe.progRp, strobe.restore}) <= 1);
  end
endmodule

// File: rtl/fg_datapath.sv
module fg_datapath
  import flash_guard_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int NUM_REGIONS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  guard_strobe_t          strobe,
  input  logic [NUM_REGIONS-1:0] progData,
  input  logic [NUM_REGIONS-1:0] loadWp,
  input  logic [NUM_REGIONS-1:0] loadRp,
  input  logic [DATA_W-1:0]      flRData,
  output logic [DATA_W-1:0]      cpuRData,
  output logic [NUM_REGIONS-1:0] wpWord,
  output logic [NUM_REGIONS-1:0] rpWord,
  output logic                   violation,
  output logic                   bootFail
);
  localparam logic [NUM_REGIONS-1:0] WP_RSV = {1'b1, {(NUM_REGIONS-1){1'b0}}};
  localparam logic [NUM_REGIONS-1:0] ALL1   = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wpWord    <= ALL1;
      rpWord    <= ALL1;
      violation <= 1'b0;
    end else begin
      violation <= strobe.flagViol;
      if (strobe.loadWords) begin
        wpWord <= loadWp | WP_RSV;
        rpWord <= loadRp;
      end else if (strobe.restore) begin
        wpWord <= ALL1;
        rpWord <= ALL1;
      end else begin
        if (strobe.progWp) wpWord <= wpWord & (progData | WP_RSV);
        if (strobe.progRp) rpWord <= rpWord & progData;
      end
    end
  end

  assign cpuRData = strobe.zeroData ? '0 : flRData;
  assign bootFail = !rpWord[0];

  p_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.restore && !strobe.loadWords |=> (wpWord == ALL1) && (rpWord == ALL1));
  p_wp_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.progWp |=> wpWord[NUM_REGIONS-1]);
  p_prog_clears_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.progRp && !strobe.loadWords |=> (rpWord & ~$past(rpWord)) == '0);
  p_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadWords |=> rpWord == $past(loadRp));
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 16,
  parameter int REGION_BITS = 14,
  parameter int BASE_REGION = 2,
  parameter int NUM_REGIONS = 8,
  parameter int SECTOR_BITS = 12,
  parameter int WP_ADDR     = 'h27FFC,
  parameter int RP_ADDR     = 'h27FFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWData,
  output logic [DATA_W-1:0] cpuRData,
  input  logic              dbgOverride,
  input  logic              loadValid,
  input  logic [7:0]        loadWp,
  input  logic [7:0]        loadRp,
  output logic              flReqValid,
  output logic [1:0]        flKind,
  output logic [ADDR_W-1:0] flAddr,
  output logic [DATA_W-1:0] flWData,
  input  logic [DATA_W-1:0] flRData,
  output logic              violation,
  output logic              bootFail
);
  localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(BASE_REGION << REGION_BITS);
  localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(((BASE_REGION + NUM_REGIONS) << REGION_BITS) - 1);

  guard_strobe_t          strobe;
  logic [NUM_REGIONS-1:0] wpWord, rpWord;

  fg_ctrl #(
    .ADDR_W(ADDR_W), .REGION_BITS(REGION_BITS), .BASE_REGION(BASE_REGION),
    .NUM_REGIONS(NUM_REGIONS), .SECTOR_BITS(SECTOR_BITS),
    .WP_ADDR(WP_ADDR), .RP_ADDR(RP_ADDR)
  ) u_ctrl (
    .reqValid(reqValid), .reqKind(reqKind), .reqAddr(reqAddr),
    .dbgOverride(dbgOverride), .loadValid(loadValid),
    .wpWord(wpWord), .rpWord(rpWord), .strobe(strobe)
  );

  fg_datapath #(.DATA_W(DATA_W), .NUM_REGIONS(NUM_REGIONS)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .progData(reqWData[NUM_REGIONS-1:0]),
    .loadWp(loadWp[NUM_REGIONS-1:0]), .loadRp(loadRp[NUM_REGIONS-1:0]),
    .flRData(flRData), .cpuRData(cpuRData),
    .wpWord(wpWord), .rpWord(rpWord),
    .violation(violation), .bootFail(bootFail)
  );

  assign flReqValid = strobe.fwd;
  assign flKind     = reqKind;
  assign flAddr     = reqAddr;
  assign flWData    = reqWData;

  p_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && reqKind == KIND_FETCH |-> flReqValid && cpuRData == flRData);
  p_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && reqKind == KIND_READ && !flReqValid |-> cpuRData == '0);
  p_debug_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && dbgOverride |-> flReqValid);
  p_outside_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && (reqAddr < WIN_LO || reqAddr > WIN_HI) |-> flReqValid);
  p_viol_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && !flReqValid |=> violation);
  p_viol_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !violation);
endmodule

// File: tb/flash_guard_tb.sv
module flash_guard_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = '0;
  logic [17:0] reqAddr = '0;
  logic [15:0] reqWData = '0;
  logic [15:0] cpuRData;
  logic        dbgOverride = 1'b0;
  logic        loadValid = 1'b0;
  logic [7:0]  loadWp = '0, loadRp = '0;
  logic        flReqValid;
  logic [1:0]  flKind;
  logic [17:0] flAddr;
  logic [15:0] flWData;
  logic [15:0] flRData;
  logic        violation, bootFail;

  int checks = 0, failures = 0;
  logic [7:0] wpM = 8'hFF, rpM = 8'hFF;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign flRData = flAddr[15:0] ^ 16'h5AC3;

  flash_guard u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqWData(reqWData), .cpuRData(cpuRData),
    .dbgOverride(dbgOverride), .loadValid(loadValid), .loadWp(loadWp),
    .loadRp(loadRp), .flReqValid(flReqValid), .flKind(flKind),
    .flAddr(flAddr), .flWData(flWData), .flRData(flRData),
    .violation(violation), .bootFail(bootFail)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Issue one request at a falling edge; check the same-cycle results, then the flag.
  task automatic doReq(input string tag, input logic [1:0] k, input logic [17:0] a,
                       input logic [15:0] d, input logic expFwd, input logic expZero,
                       input logic expViol);
    @(negedge clk);
    reqValid = 1'b1; reqKind = k; reqAddr = a; reqWData = d;
    #1;
    chk({tag, " fwd"}, 32'(flReqValid), 32'(expFwd));
    if (k == 2'd0 || k == 2'd1)
      chk({tag, " rdata"}, 32'(cpuRData), expZero ? 32'h0 : 32'(a[15:0] ^ 16'h5AC3));
    @(posedge clk); #1;
    chk({tag, " violation"}, 32'(violation), 32'(expViol));
    reqValid = 1'b0;
  endtask

  task automatic loadWords(input logic [7:0] w, input logic [7:0] r);
    @(negedge clk);
    loadValid = 1'b1; loadWp = w; loadRp = r;
    @(posedge clk); #1;
    loadValid = 1'b0;
    wpM = w | 8'h80; rpM = r;
    chk("R11 R9 bootFail after load", 32'(bootFail), 32'(!r[0]));
  endtask

  // Sweep all 16 regions, all kinds, with the model words and current override.
  task automatic sweep(input logic dbg);
    dbgOverride = dbg;
    for (int r = 0; r < 16; r++) begin
      for (int k = 0; k < 4; k++) begin
        logic [17:0] a;
        logic inWin, wrOk, rdOk, fwd, zero;
        int i;
        string tag;
        a = 18'(r << 14) | 18'h100;
        inWin = (r >= 2) && (r <= 9);
        i = r - 2;
        wrOk = dbg || !inWin || i == 7 || wpM[i[2:0]];
        rdOk = dbg || !inWin || i == 0 || rpM[i[2:0]];
        fwd = (k == 0) ? 1'b1 : (k == 1) ? rdOk : wrOk;
        zero = (k == 1) && !rdOk;
        if (dbg) tag = "R7";
        else if (!inWin) tag = "R5";
        else if (k == 0) tag = "R4";
        else if (k == 1) tag = "R3";
        else tag = "R2";
        doReq(tag, 2'(k), a, 16'hFFFF, fwd, zero, !fwd || zero);
      end
    end
    dbgOverride = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 violation after reset", 32'(violation), 32'h0);
    chk("R1 bootFail after reset", 32'(bootFail), 32'h0);
    sweep(1'b0);

    // Load-port patterns, with and without the override
    loadWords(8'h00, 8'h00); sweep(1'b0); sweep(1'b1);
    loadWords(8'hA5, 8'h5B); sweep(1'b0);
    loadWords(8'h5A, 8'hA4); sweep(1'b0);
    loadWords(8'h3C, 8'hC3); sweep(1'b0);

    // R10: pulse is a single cycle
    doReq("R10 blocked write", 2'd2, 18'h08100, 16'h0, 1'b0, 1'b0, 1'b1);
    @(posedge clk); #1;
    chk("R10 pulse ends", 32'(violation), 32'h0);

    // R6: protection sector erase is forwarded and restores both words
    doReq("R6 erase prot sector", 2'd3, 18'h27800, 16'h0, 1'b1, 1'b0, 1'b0);
    wpM = 8'hFF; rpM = 8'hFF;
    chk("R6 R9 bootFail cleared", 32'(bootFail), 32'h0);
    sweep(1'b0);

    // R8: program words through their flash locations
    doReq("R8 program wp", 2'd2, 18'h27FFC, 16'hFF0F, 1'b1, 1'b0, 1'b0);
    wpM = 8'h8F;
    doReq("R8 program rp", 2'd2, 18'h27FFE, 16'h00FE, 1'b1, 1'b0, 1'b0);
    rpM = 8'hFE;
    chk("R9 bootFail on reserved bit", 32'(bootFail), 32'h1);
    doReq("R8 program rp again", 2'd2, 18'h27FFE, 16'h007F, 1'b1, 1'b0, 1'b0);
    rpM = 8'h7E;
    doReq("R8 try to set wp bits", 2'd2, 18'h27FFC, 16'hFFFF, 1'b1, 1'b0, 1'b0);
    sweep(1'b0);

    // R6: erase of a different sector in the top region does not restore
    doReq("R6 erase other sector", 2'd3, 18'h24000, 16'h0, 1'b1, 1'b0, 1'b0);
    doReq("R3 top region still hidden", 2'd1, 18'h24100, 16'h0, 1'b0, 1'b1, 1'b1);
    doReq("R6 erase prot sector again", 2'd3, 18'h27000, 16'h0, 1'b1, 1'b0, 1'b0);
    wpM = 8'hFF; rpM = 8'hFF;
    doReq("R6 top region readable", 2'd1, 18'h24100, 16'h0, 1'b1, 1'b0, 1'b0);

    // R11: load wins over a same-cycle protection sector erase
    @(negedge clk);
    reqValid = 1'b1; reqKind = 2'd3; reqAddr = 18'h27800;
    loadValid = 1'b1; loadWp = 8'h00; loadRp = 8'h02;
    @(posedge clk); #1;
    reqValid = 1'b0; loadValid = 1'b0;
    wpM = 8'h80; rpM = 8'h02;
    chk("R11 load priority bootFail", 32'(bootFail), 32'h1);
    sweep(1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule